// File: doc/BRIEF.md
# TPM FIFO Command Sequencer

This block runs one full command/response exchange with a TPM-style device through its FIFO register interface. The caller places a command in a byte-addressable buffer, gives its length and pulses `start`. The block then handles the whole exchange. It checks the length encoded in the command against the supplied length. It arms the device with a command-ready write to the status register and streams the command into the data FIFO in chunks that the device's burst count allows. It then writes the go bit, polls status at a fixed spacing until a response is available, and copies the response into a byte-writable buffer. At the end it reports the response length or an error code.

Register traffic leaves through a simple transaction port. The block holds a request with an address, a direction and a byte count. The transport moves one byte per `bus_beat` pulse and closes the transaction with `bus_done`, which may carry `bus_err`. `bus_done` never arrives in the same cycle as a beat. Multi-byte status values travel least significant byte first. The command buffer read is combinational: `cmd_data` reflects `cmd_addr` in the same cycle.

Top module: `tpm_fifo_seq`

## Requirements
- R1: After `start`, the block reads command bytes 2..5 as a big-endian 32-bit length. If that value differs from `cmd_len`, the exchange ends with `err` set and `err_code` 1, and no bus transaction is issued.
- R2: Status writes go to address 0xD40018 as 4-byte transactions. The order is fixed: command-ready (value 0x40) first, go (value 0x20) once the whole command has been written, and command-ready (0x40) again after a successful response.
- R3: Before each FIFO chunk the block reads status and takes the burst count from bits 23:8. While the burst count is zero it reads status again. Each FIFO transaction carries min(bytes remaining, burst count, 64) bytes.
- R4: After the go write, the block waits `POLL_GAP` idle cycles before each status poll. It proceeds once bits 7 (valid) and 4 (data available) are both set. After `MAX_POLLS` polls without success it ends with `err_code` 3.
- R5: The response is read first as a 6-byte header, and its total length is taken big-endian from bytes 2..5. If the total is below 7 or above `rsp_max`, the exchange ends with `err_code` 4.
- R6: After all response bytes except the last have been read, status must show valid and data-available together; otherwise the exchange ends with `err_code` 5.
- R7: After the last byte, the status masked to bits 7 and 4 must equal valid alone; otherwise `err_code` 6. On success `resp_len` holds the total and `err` is 0.
- R8: A transaction closed with `bus_err` ends the exchange at once with `err_code` 2, and no further transaction follows.
- R9: `done` is a single-cycle pulse with `busy` low. `err` and `err_code` hold until the next `start`.
- R10: While a transaction is open, its address, direction and count stay constant. FIFO transactions use address 0xD40024 with a count of 1..64.
- R11: Each response byte is written to `rsp_addr` equal to its offset in the response, always below `rsp_max`, with command bytes and response bytes transferred in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an exchange (accepted when idle) |
| cmd_len | input | LW | Command length in bytes |
| rsp_max | input | LW | Response buffer capacity in bytes |
| cmd_addr | output | LW | Command buffer byte address |
| cmd_data | input | 8 | Command byte at `cmd_addr` |
| rsp_we | output | 1 | Response byte write strobe |
| rsp_addr | output | LW | Response byte address |
| rsp_data | output | 8 | Response byte |
| bus_req | output | 1 | Transaction open |
| bus_wr | output | 1 | 1 = write to device |
| bus_addr | output | 24 | Register address |
| bus_cnt | output | 7 | Transaction byte count |
| bus_wbyte | output | 8 | Byte to write on the current beat |
| bus_beat | input | 1 | One byte moved |
| bus_rbyte | input | 8 | Byte read on the current beat |
| bus_done | input | 1 | Transaction closed |
| bus_err | input | 1 | Transaction failed (with `bus_done`) |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange finished (one cycle) |
| err | output | 1 | Sticky failure flag |
| err_code | output | 3 | Failure cause |
| resp_len | output | LW | Response length on success |

## Verification
The hardest paths to reach are the two response status checks. Reaching them needs a device that streams a valid response and then reports data-available wrongly, either dropping it one byte early or keeping it after the final byte. The bench's device model serves the real byte stream and has per-test switches that shift its data-available limit by one byte in either direction, so both checks fail at exactly the boundary byte. A zero burst count on the first reads and a burst larger than 64 drive the chunk arithmetic to both limits.

// File: rtl/tpm_fifo_seq.sv
module tpm_fifo_seq #(
  parameter int LW = 16,
  parameter int POLL_GAP = 100000,
  parameter int MAX_POLLS = 120000,
  parameter logic [23:0] STS_ADDR = 24'hD40018,
  parameter logic [23:0] FIFO_ADDR = 24'hD40024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] cmd_len,
  input  logic [LW-1:0] rsp_max,
  output logic [LW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  output logic          rsp_we,
  output logic [LW-1:0] rsp_addr,
  output logic [7:0]    rsp_data,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [23:0]   bus_addr,
  output logic [6:0]    bus_cnt,
  output logic [7:0]    bus_wbyte,
  input  logic          bus_beat,
  input  logic [7:0]    bus_rbyte,
  input  logic          bus_done,
  input  logic          bus_err,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [2:0]    err_code,
  output logic [LW-1:0] resp_len
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [7:0] B_VALID = 8'h80;
  localparam logic [7:0] B_RDY   = 8'h40;
  localparam logic [7:0] B_GO    = 8'h20;
  localparam logic [7:0] B_DAV   = 8'h10;
  localparam logic [7:0] SEL     = B_VALID | B_DAV;

  typedef enum logic [3:0] {
    S_IDLE, S_LEN, S_RDY, S_BRST, S_XFER, S_GO, S_GAP, S_POLL, S_MCHK, S_ECHK, S_FIN
  } st_t;
  typedef enum logic [1:0] {PH_TX, PH_HDR, PH_BODY, PH_LAST} ph_t;

  st_t st;
  ph_t ph;
  logic [LW-1:0] pos, target;
  logic [31:0]   field, total;
  logic [23:0]   sts;
  logic [6:0]    chunk, bidx;
  logic [GW-1:0] gap;
  logic [PW-1:0] polls;

  wire stsop = st inside {S_RDY, S_BRST, S_GO, S_POLL, S_MCHK, S_ECHK, S_FIN};
  assign bus_req  = stsop || st == S_XFER;
  assign bus_wr   = (st inside {S_RDY, S_GO, S_FIN}) || (st == S_XFER && ph == PH_TX);
  assign bus_addr = (st == S_XFER) ? FIFO_ADDR : STS_ADDR;
  assign bus_cnt  = (st == S_XFER) ? chunk : 7'd4;
  assign bus_wbyte = (st == S_XFER) ? cmd_data :
                     (bidx != 7'd0) ? 8'h00 :
                     (st == S_GO) ? B_GO :
                     (st inside {S_RDY, S_FIN}) ? B_RDY : 8'h00;

  assign cmd_addr = pos;
  assign rsp_we   = st == S_XFER && ph != PH_TX && bus_beat;
  assign rsp_addr = pos;
  assign rsp_data = bus_rbyte;
  assign busy     = st != S_IDLE;

  wire fin  = bus_req && bus_done;
  wire berr = fin && bus_err;
  wire [7:0] sbits = sts[7:0] & SEL;

  wire [31:0] rem  = 32'(target - pos);
  wire [31:0] bcnt = {16'b0, sts[23:8]};
  wire [31:0] pick = (rem < bcnt) ? rem : bcnt;
  wire [6:0]  nchunk = (pick > 32'd64) ? 7'd64 : pick[6:0];
  wire [31:0] newfield = {field[23:0], cmd_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bidx <= '0;
    else if (bus_done) bidx <= '0;
    else if (bus_beat) bidx <= bidx + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else if (stsop && bus_beat && !bus_wr) begin
      case (bidx)
        7'd0: sts[7:0]   <= bus_rbyte;
        7'd1: sts[15:8]  <= bus_rbyte;
        7'd2: sts[23:16] <= bus_rbyte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_TX; pos <= '0; target <= '0;
      field <= '0; total <= '0; chunk <= 7'd1; gap <= '0; polls <= '0;
      done <= 1'b0; err <= 1'b0; err_code <= 3'd0; resp_len <= '0;
    end else begin
      done <= 1'b0;
      if (berr) begin
        st <= S_IDLE; err <= 1'b1; err_code <= 3'd2; done <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            err <= 1'b0; err_code <= 3'd0; resp_len <= '0;
            pos <= LW'(2); field <= '0; st <= S_LEN;
          end
          S_LEN: begin
            field <= newfield;
            pos <= pos + LW'(1);
            if (pos == LW'(5)) begin
              if (newfield == 32'(cmd_len)) begin
                st <= S_RDY; pos <= '0;
              end else begin
                st <= S_IDLE; err <= 1'b1; err_code <= 3'd1; done <= 1'b1;
              end
            end
          end
          S_RDY: if (fin) begin
            ph <= PH_TX; target <= cmd_len; pos <= '0;
            st <= (cmd_len == '0) ? S_GO : S_BRST;
          end
          S_BRST: if (fin && sts[23:8] != 16'd0) begin
            chunk <= nchunk; st <= S_XFER;
          end
          S_XFER: begin
            if (bus_beat) begin
              pos <= pos + LW'(1);
              if (ph == PH_HDR && pos >= LW'(2) && pos <= LW'(5))
                total <= {total[23:0], bus_rbyte};
            end
            if (fin) begin
              if (pos != target) st <= S_BRST;
              else begin
                case (ph)
                  PH_TX: st <= S_GO;
                  PH_HDR:
                    if (total < 32'd7 || total > 32'(rsp_max)) begin
                      st <= S_IDLE; err <= 1'b1; err_code <= 3'd4; done <= 1'b1;
                    end else begin
                      ph <= PH_BODY; target <= total[LW-1:0] - LW'(1);
                      st <= (total == 32'd7) ? S_MCHK : S_BRST;
                    end
                  PH_BODY: st <= S_MCHK;
                  default: st <= S_ECHK;
                endcase
              end
            end
          end
          S_GO: if (fin) begin
            gap <= '0; polls <= '0; st <= S_GAP;
          end
          S_GAP:
            if (gap == GW'(POLL_GAP - 1)) st <= S_POLL;
            else gap <= gap + GW'(1);
          S_POLL: if (fin) begin
            if (sbits == SEL) begin
              ph <= PH_HDR; target <= LW'(6); pos <= '0; total <= '0; st <= S_BRST;
            end else if (polls == PW'(MAX_POLLS - 1)) begin
              st <= S_IDLE; err <= 1'b1; err_code <= 3'd3; done <= 1'b1;
            end else begin
              polls <= polls + PW'(1); gap <= '0; st <= S_GAP;
            end
          end
          S_MCHK: if (fin) begin
            if (sbits == SEL) begin
              ph <= PH_LAST; target <= total[LW-1:0]; st <= S_BRST;
            end else begin
              st <= S_IDLE; err <= 1'b1; err_code <= 3'd5; done <= 1'b1;
            end
          end
          S_ECHK: if (fin) begin
            if (sbits == B_VALID) st <= S_FIN;
            else begin
              st <= S_IDLE; err <= 1'b1; err_code <= 3'd6; done <= 1'b1;
            end
          end
          S_FIN: if (fin) begin
            st <= S_IDLE; done <= 1'b1; resp_len <= total[LW-1:0];
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tpm_fifo_seq_chk.sv
module tpm_fifo_seq_chk #(
  parameter int LW = 16,
  parameter logic [23:0] FIFO_ADDR = 24'hD40024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] rsp_max,
  input logic          rsp_we,
  input logic [LW-1:0] rsp_addr,
  input logic          bus_req,
  input logic          bus_wr,
  input logic [23:0]   bus_addr,
  input logic [6:0]    bus_cnt,
  input logic          bus_done,
  input logic          busy,
  input logic          done,
  input logic          err
);
  assert_txn_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_cnt)));

  assert_chunk_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == FIFO_ADDR) |-> (bus_cnt >= 7'd1 && bus_cnt <= 7'd64));

  assert_rsp_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> (rsp_addr < rsp_max && !bus_wr));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
endmodule

bind tpm_fifo_seq tpm_fifo_seq_chk #(.LW(LW), .FIFO_ADDR(FIFO_ADDR)) u_chk (.*);

// File: tb/sim_tpm_fifo_seq.sv
module sim_tpm_fifo_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GAPC = 4;
  localparam int MAXP = 10;
  localparam logic [23:0] STSA = 24'hD40018;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] cmd_len = 0, rsp_max = 0;
  logic [15:0] cmd_addr, rsp_addr, resp_len;
  logic [7:0]  cmd_data, rsp_data, bus_wbyte;
  logic        rsp_we, bus_req, bus_wr, busy, done, err;
  logic [23:0] bus_addr;
  logic [6:0]  bus_cnt;
  logic [2:0]  err_code;
  logic        bus_beat = 0, bus_done = 0, bus_err = 0;
  logic [7:0]  bus_rbyte = 0;

  logic [7:0] cmdbuf [0:255];
  logic [7:0] rspsrc [0:255];
  logic [7:0] rspbuf [0:255];
  logic [7:0] devcmd [0:255];
  logic [31:0] swlog [0:7];

  int errors = 0, checks = 0;
  int dev_burst, zero_left, ready_after, reads_after_go, rptr, rtot, wptr;
  int err_at, txn, nsw, fifo_wr_txns, max_chunk, cyc;
  bit go_seen, drop_early, extra_tail;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmd_data = cmdbuf[cmd_addr[7:0]];

  tpm_fifo_seq #(.POLL_GAP(GAPC), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .rsp_max(rsp_max),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_we(rsp_we), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_cnt(bus_cnt), .bus_wbyte(bus_wbyte), .bus_beat(bus_beat), .bus_rbyte(bus_rbyte),
    .bus_done(bus_done), .bus_err(bus_err), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .resp_len(resp_len));

  always @(posedge clk) if (rsp_we) rspbuf[rsp_addr[7:0]] <= rsp_data;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_sts();
    int b, lim;
    bit dav;
    b = dev_burst;
    if (zero_left > 0) begin b = 0; zero_left--; end
    if (go_seen) reads_after_go++;
    lim = rtot - (drop_early ? 1 : 0) + (extra_tail ? 1 : 0);
    dav = go_seen && reads_after_go > ready_after && rptr < lim;
    return 32'h80 | (dav ? 32'h10 : 32'h0) | ((b & 32'hFFFF) << 8);
  endfunction

  task automatic serve();
    int n;
    bit wr;
    logic [23:0] a;
    logic [31:0] w, sv;
    n = int'(bus_cnt); wr = bus_wr; a = bus_addr; w = 0; sv = 0;
    txn++;
    if (a == STSA && !wr) sv = make_sts();
    for (int i = 0; i < n; i++) begin
      bus_beat = 1;
      if (a == STSA) begin
        if (i < 4) begin
          if (wr) w[8*i +: 8] = bus_wbyte;
          else bus_rbyte = sv[8*i +: 8];
        end
      end else if (wr) begin
        devcmd[wptr[7:0]] = bus_wbyte; wptr++;
      end else begin
        bus_rbyte = rspsrc[rptr[7:0]]; rptr++;
      end
      @(negedge clk);
    end
    bus_beat = 0;
    bus_done = 1;
    bus_err = (txn == err_at);
    if (a == STSA && wr) begin
      if (nsw < 8) swlog[nsw] = w;
      nsw++;
      if (w == 32'h20) go_seen = 1;
    end
    if (a != STSA && wr) begin
      fifo_wr_txns++;
      if (n > max_chunk) max_chunk = n;
    end
    @(negedge clk);
    bus_done = 0; bus_err = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (bus_req) serve();
    end
  end

  task automatic dev_reset(input int burst, input int zeros, input int rdy);
    dev_burst = burst; zero_left = zeros; ready_after = rdy; reads_after_go = 0;
    rptr = 0; wptr = 0; err_at = -1; txn = 0; nsw = 0; fifo_wr_txns = 0; max_chunk = 0;
    go_seen = 0; drop_early = 0; extra_tail = 0;
    for (int i = 0; i < 256; i++) begin devcmd[i] = 0; rspbuf[i] = 0; end
  endtask

  task automatic fill_cmd(input int len, input int fld);
    for (int i = 0; i < 256; i++) cmdbuf[i] = 8'(i * 7 + 3);
    cmdbuf[2] = 8'(fld >> 24); cmdbuf[3] = 8'(fld >> 16);
    cmdbuf[4] = 8'(fld >> 8);  cmdbuf[5] = 8'(fld);
    cmd_len = 16'(len);
  endtask

  task automatic fill_rsp(input int tot);
    for (int i = 0; i < 256; i++) rspsrc[i] = 8'(8'hA0 + i * 5);
    rspsrc[2] = 8'(tot >> 24); rspsrc[3] = 8'(tot >> 16);
    rspsrc[4] = 8'(tot >> 8);  rspsrc[5] = 8'(tot);
    rtot = tot;
  endtask

  task automatic run();
    cyc = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!done) chk("R9 done within limit", 0, 1);
  endtask

  task automatic cmp_data(input string req, input int clen, input int rlen);
    int bad = 0;
    for (int i = 0; i < clen; i++) if (devcmd[i] != cmdbuf[i]) bad++;
    for (int i = 0; i < rlen; i++) if (rspbuf[i] != rspsrc[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset err", int'(err), 0);
    chk("R10 reset bus_req", int'(bus_req), 0);
    chk("R9 reset done", int'(done), 0);
  endtask

  task automatic t_basic();
    dev_reset(64, 0, 3); fill_cmd(10, 10); fill_rsp(12); rsp_max = 40;
    run();
    chk("R7 basic err", int'(err), 0);
    chk("R7 basic resp_len", int'(resp_len), 12);
    chk("R2 status write count", nsw, 3);
    chk("R2 first write ready", int'(swlog[0]), 32'h40);
    chk("R2 second write go", int'(swlog[1]), 32'h20);
    chk("R2 final write ready", int'(swlog[2]), 32'h40);
    cmp_data("R11 basic data", 10, 12);
  endtask

  task automatic t_small_burst();
    dev_reset(3, 2, 0); fill_cmd(20, 20); fill_rsp(9); rsp_max = 9;
    run();
    chk("R3 small burst err", int'(err), 0);
    chk("R3 write chunk count", fifo_wr_txns, 7);
    chk("R3 max chunk", max_chunk, 3);
    chk("R7 small burst resp_len", int'(resp_len), 9);
    cmp_data("R11 small burst data", 20, 9);
  endtask

  task automatic t_cap64();
    dev_reset(200, 0, 0); fill_cmd(100, 100); fill_rsp(70); rsp_max = 100;
    run();
    chk("R3 cap err", int'(err), 0);
    chk("R3 cap chunk count", fifo_wr_txns, 2);
    chk("R3 cap max chunk", max_chunk, 64);
    cmp_data("R11 cap data", 100, 70);
  endtask

  task automatic t_mismatch();
    dev_reset(64, 0, 0); fill_cmd(11, 10); fill_rsp(12); rsp_max = 40;
    run();
    chk("R1 mismatch err", int'(err), 1);
    chk("R1 mismatch code", int'(err_code), 1);
    chk("R1 no bus traffic", txn, 0);
  endtask

  task automatic t_rsp_len();
    dev_reset(64, 0, 0); fill_cmd(8, 8); fill_rsp(50); rsp_max = 40;
    run();
    chk("R5 too long code", int'(err_code), 4);
    chk("R11 header only written", int'(rspbuf[6]), 0);
    dev_reset(64, 0, 0); fill_cmd(8, 8); fill_rsp(5); rsp_max = 40;
    run();
    chk("R5 too short code", int'(err_code), 4);
  endtask

  task automatic t_timeout();
    dev_reset(64, 0, 1000); fill_cmd(8, 8); fill_rsp(12); rsp_max = 40;
    run();
    chk("R4 timeout code", int'(err_code), 3);
    chk("R4 poll count", reads_after_go, MAXP);
    chk("R4 poll spacing", int'(cyc >= MAXP * GAPC), 1);
  endtask

  task automatic t_mid();
    dev_reset(64, 0, 0); fill_cmd(8, 8); fill_rsp(12); rsp_max = 40;
    drop_early = 1;
    run();
    chk("R6 mid status code", int'(err_code), 5);
  endtask

  task automatic t_end();
    dev_reset(64, 0, 0); fill_cmd(8, 8); fill_rsp(7); rsp_max = 40;
    extra_tail = 1;
    run();
    chk("R7 end status code", int'(err_code), 6);
    chk("R2 no final ready on failure", nsw, 2);
  endtask

  task automatic t_buserr();
    int t0;
    dev_reset(64, 0, 0); fill_cmd(8, 8); fill_rsp(12); rsp_max = 40;
    err_at = 3;
    run();
    chk("R8 bus error code", int'(err_code), 2);
    t0 = txn;
    repeat (20) @(negedge clk);
    chk("R8 no traffic after error", txn, t0);
    chk("R9 err sticky", int'(err), 1);
    chk("R9 code sticky", int'(err_code), 2);
    dev_reset(64, 0, 0); fill_cmd(8, 8); fill_rsp(7); rsp_max = 7;
    run();
    chk("R9 err cleared by start", int'(err), 0);
    chk("R7 minimal response len", int'(resp_len), 7);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    dev_reset(64, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_small_burst();
    t_cap64();
    t_mismatch();
    t_rsp_len();
    t_timeout();
    t_mid();
    t_end();
    t_buserr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule